// File: doc/BRIEF.md
# Segment Selector Privilege Checker

This block decides whether a task may reach a segment named by a 16-bit selector. The selector is split into a descriptor index, a table bit that picks the global or the local descriptor table, and a two-bit requested privilege level. The block takes these together with the running task's current privilege level and the type and privilege level of the target descriptor. For a call gate it also takes the gate's entry offset and the privilege level of the segment behind the gate. It then grants the access or raises a general-protection fault. Descriptor contents are fetched elsewhere and arrive with the request.

Privilege numbers run from 0, the most trusted, to 3, the level of user tasks. The check uses the weaker of two levels: the task's own level and the level requested in the selector. A plain data or code access may only reach segments at that level or at a numerically larger one. A call gate is the one path into a more trusted segment. When the gate is used, the entry offset comes from the gate and not from the caller.

Requests use a valid/ready handshake. The decision, the decoded index and table bit, the effective offset and the resulting privilege level are registered. They appear on a one-cycle response pulse in the cycle after the request is accepted. A fault carries vector 0Dh. The index and table bit on the same pulse are enough to build an error code.

Top module: `segPrivChecker`

## Requirements
- R1: On each response, descIndex equals selector bits 15..3 of the accepted request and tableSel equals selector bit 2 (0 = global table, 1 = local table).
- R2: The effective level is the numerically larger of curPriv and selector bits 1..0. A request with descType 0 (data) or 1 (code) is granted exactly when descPriv is numerically greater than or equal to the effective level.
- R3: Unless a call gate is both selected and granted, targetOffset equals the request's callerOffset and newPriv equals curPriv.
- R4: A denied request produces fault high for exactly the one response cycle, with faultVector = 8'h0D. A granted request has faultVector = 8'h00.
- R5: A request with descType 2 (call gate) is granted exactly when descPriv (the gate's own level) is numerically greater than or equal to the effective level and gateTargetPriv is numerically less than or equal to curPriv. A granted gate gives targetOffset = gateOffset and newPriv = gateTargetPriv.
- R6: A request with descType 3 (system segment held only in the global table) is denied whenever selector bit 2 is 1. With bit 2 at 0 it follows the privilege rule of R2.
- R7: respValid is high in exactly the cycle after a cycle with reqValid and reqReady both high. In that cycle exactly one of grant and fault is high. Outside it both are low.
- R8: While rstN is low, reqReady, respValid, grant and fault are all low. After reset is released, reqReady is high from the next clock edge on.
- R9: Cycles with reqValid low produce no response, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| selector | input | 16 | Segment selector: index, table bit, requested level |
| curPriv | input | 2 | Privilege level of the running task |
| descPriv | input | 2 | Privilege level of the addressed descriptor (of the gate itself for a gate) |
| descType | input | 2 | 0 data, 1 code, 2 call gate, 3 global-only system segment |
| callerOffset | input | 32 | Offset supplied by the caller |
| gateOffset | input | 32 | Entry offset held in a call gate |
| gateTargetPriv | input | 2 | Privilege level of the segment a gate leads to |
| respValid | output | 1 | One-cycle response pulse |
| grant | output | 1 | Access granted |
| fault | output | 1 | General-protection fault |
| faultVector | output | 8 | 8'h0D on fault, else 0 |
| descIndex | output | 13 | Descriptor index from the selector |
| tableSel | output | 1 | Table bit from the selector |
| targetOffset | output | 32 | Effective target offset |
| newPriv | output | 2 | Privilege level after the access |

## Verification
The bench builds the block with its default parameters: a 16-bit selector, two-bit privilege levels and 32-bit offsets. With two-bit levels the whole decision space is small. That allows a full sweep over every combination of current level, requested level, descriptor level, descriptor type, table bit and gate target level, 2048 requests in all. Each response is compared with a decision worked out arithmetically in the bench. Reset behaviour and idle cycles with unrelated input traffic are also covered.

// File: rtl/segPrivPkg.sv
package segPrivPkg;

  localparam int SEL_W   = 16;
  localparam int PL_W    = 2;
  localparam int IDX_W   = SEL_W - 3;
  localparam int OFF_W   = 32;
  localparam int VEC_W   = 8;
  localparam logic [VEC_W-1:0] GP_VECTOR = 8'h0D;

  typedef enum logic [1:0] {
    DESC_DATA   = 2'd0,
    DESC_CODE   = 2'd1,
    DESC_GATE   = 2'd2,
    DESC_SYSGLB = 2'd3
  } descKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic fault;
    logic useGate;
  } strobe_t;

endpackage

// File: rtl/segPrivCtrl.sv
module segPrivCtrl
  import segPrivPkg::*;
#(
  parameter int PLW = PL_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [PLW-1:0]  reqPriv,
  input  logic            selTable,
  input  logic [PLW-1:0]  curPriv,
  input  logic [PLW-1:0]  descPriv,
  input  descKind_t       descType,
  input  logic [PLW-1:0]  gateTargetPriv,
  output strobe_t         strb,
  output logic            respValid,
  output logic            grant,
  output logic            fault
);

  logic           readyQ;
  logic           accept;
  logic [PLW-1:0] effPriv;
  logic           privOk;
  logic           allowed;
  logic           isGate;

  assign reqReady = readyQ;
  assign accept   = reqValid && readyQ;

  // weaker of running level and requested level
  assign effPriv = (curPriv > reqPriv) ? curPriv : reqPriv;
  assign privOk  = (descPriv >= effPriv);
  assign isGate  = (descType == DESC_GATE);

  always_comb begin
    unique case (descType)
      DESC_DATA,
      DESC_CODE:   allowed = privOk;
      DESC_GATE:   allowed = privOk && (gateTargetPriv <= curPriv);
      DESC_SYSGLB: allowed = privOk && !selTable;
      default:     allowed = 1'b0;
    endcase
  end

  always_comb begin
    strb.load    = accept;
    strb.fault   = accept && !allowed;
    strb.useGate = accept && allowed && isGate;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      respValid <= 1'b0;
      grant     <= 1'b0;
      fault     <= 1'b0;
    end else begin
      readyQ    <= 1'b1;
      respValid <= accept;
      grant     <= accept && allowed;
      fault     <= accept && !allowed;
    end
  end

endmodule

// File: rtl/segPrivDatapath.sv
module segPrivDatapath
  import segPrivPkg::*;
#(
  parameter int IDXW = IDX_W,
  parameter int PLW  = PL_W,
  parameter int OFFW = OFF_W,
  parameter int VECW = VEC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [IDXW-1:0]  selIndex,
  input  logic             selTable,
  input  logic [OFFW-1:0]  callerOffset,
  input  logic [OFFW-1:0]  gateOffset,
  input  logic [PLW-1:0]   curPriv,
  input  logic [PLW-1:0]   gateTargetPriv,
  output logic [IDXW-1:0]  descIndex,
  output logic             tableSel,
  output logic [OFFW-1:0]  targetOffset,
  output logic [PLW-1:0]   newPriv,
  output logic [VECW-1:0]  faultVector
);

  logic [OFFW-1:0] offNext;
  logic [PLW-1:0]  privNext;

  assign offNext  = strb.useGate ? gateOffset     : callerOffset;
  assign privNext = strb.useGate ? gateTargetPriv : curPriv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descIndex    <= '0;
      tableSel     <= 1'b0;
      targetOffset <= '0;
      newPriv      <= '0;
      faultVector  <= '0;
    end else if (strb.load) begin
      descIndex    <= selIndex;
      tableSel     <= selTable;
      targetOffset <= offNext;
      newPriv      <= privNext;
      faultVector  <= strb.fault ? VECW'(GP_VECTOR) : '0;
    end
  end

endmodule

// File: rtl/segPrivChecker.sv
module segPrivChecker
  import segPrivPkg::*;
#(
  parameter int SELW = SEL_W,
  parameter int PLW  = PL_W,
  parameter int OFFW = OFF_W,
  localparam int IDXW = SELW - 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [SELW-1:0]  selector,
  input  logic [PLW-1:0]   curPriv,
  input  logic [PLW-1:0]   descPriv,
  input  logic [1:0]       descType,
  input  logic [OFFW-1:0]  callerOffset,
  input  logic [OFFW-1:0]  gateOffset,
  input  logic [PLW-1:0]   gateTargetPriv,
  output logic             respValid,
  output logic             grant,
  output logic             fault,
  output logic [VEC_W-1:0] faultVector,
  output logic [IDXW-1:0]  descIndex,
  output logic             tableSel,
  output logic [OFFW-1:0]  targetOffset,
  output logic [PLW-1:0]   newPriv
);

  strobe_t         strb;
  logic [IDXW-1:0] selIndex;
  logic            selTable;
  logic [PLW-1:0]  reqPriv;

  assign selIndex = selector[SELW-1:3];
  assign selTable = selector[2];
  assign reqPriv  = selector[PLW-1:0];

  segPrivCtrl #(.PLW(PLW)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqPriv(reqPriv), .selTable(selTable),
    .curPriv(curPriv), .descPriv(descPriv),
    .descType(descKind_t'(descType)),
    .gateTargetPriv(gateTargetPriv),
    .strb(strb),
    .respValid(respValid), .grant(grant), .fault(fault)
  );

  segPrivDatapath #(.IDXW(IDXW), .PLW(PLW), .OFFW(OFFW), .VECW(VEC_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .selIndex(selIndex), .selTable(selTable),
    .callerOffset(callerOffset), .gateOffset(gateOffset),
    .curPriv(curPriv), .gateTargetPriv(gateTargetPriv),
    .descIndex(descIndex), .tableSel(tableSel),
    .targetOffset(targetOffset), .newPriv(newPriv),
    .faultVector(faultVector)
  );

endmodule

// File: rtl/segPrivCheckerChk.sv
module segPrivCheckerChk #(
  parameter int SELW = 16,
  parameter int PLW  = 2,
  parameter int OFFW = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [SELW-1:0] selector,
  input logic [PLW-1:0]  curPriv,
  input logic [PLW-1:0]  descPriv,
  input logic [1:0]      descType,
  input logic [OFFW-1:0] callerOffset,
  input logic [OFFW-1:0] gateOffset,
  input logic [PLW-1:0]  gateTargetPriv,
  input logic            respValid,
  input logic            grant,
  input logic            fault,
  input logic [7:0]      faultVector,
  input logic [SELW-4:0] descIndex,
  input logic            tableSel,
  input logic [OFFW-1:0] targetOffset,
  input logic [PLW-1:0]  newPriv
);

  logic acc;
  assign acc = reqValid && reqReady;

  // R7
  resp_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> respValid);

  // R9
  no_resp_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !acc |=> !respValid);

  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (grant != fault));

  // R7
  quiet_outside_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> (!grant && !fault));

  // R4
  gp_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && fault) |-> (faultVector == 8'h0D));

  // R1
  index_follows_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> (descIndex == $past(selector[SELW-1:3]) && tableSel == $past(selector[2])));

  // R6
  sys_local_denied_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc && descType == 2'd3 && selector[2]) |=> fault);

  // R3
  gate_only_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc && descType != 2'd2) |=> (targetOffset == $past(callerOffset)));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!reqReady && !respValid && !grant && !fault));

endmodule

bind segPrivChecker segPrivCheckerChk #(.SELW(SELW), .PLW(PLW), .OFFW(OFFW)) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .selector(selector), .curPriv(curPriv), .descPriv(descPriv),
  .descType(descType), .callerOffset(callerOffset), .gateOffset(gateOffset),
  .gateTargetPriv(gateTargetPriv), .respValid(respValid), .grant(grant),
  .fault(fault), .faultVector(faultVector), .descIndex(descIndex),
  .tableSel(tableSel), .targetOffset(targetOffset), .newPriv(newPriv)
);

// File: tb/test_segPrivChecker.sv
module test_segPrivChecker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] selector = '0;
  logic [1:0]  curPriv = '0, descPriv = '0, descType = '0, gateTargetPriv = '0;
  logic [31:0] callerOffset = '0, gateOffset = '0;
  logic        respValid, grant, fault, tableSel;
  logic [7:0]  faultVector;
  logic [12:0] descIndex;
  logic [31:0] targetOffset;
  logic [1:0]  newPriv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segPrivChecker i_segPrivChecker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .selector(selector), .curPriv(curPriv), .descPriv(descPriv),
    .descType(descType), .callerOffset(callerOffset), .gateOffset(gateOffset),
    .gateTargetPriv(gateTargetPriv), .respValid(respValid), .grant(grant),
    .fault(fault), .faultVector(faultVector), .descIndex(descIndex),
    .tableSel(tableSel), .targetOffset(targetOffset), .newPriv(newPriv)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R8: quiet in reset
    check("R8 reset ready", {63'd0, reqReady}, 64'd0);
    check("R8 reset outputs", {61'd0, respValid, grant, fault}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 ready after reset", {63'd0, reqReady}, 64'd1);

    // R9: idle traffic yields no response
    for (int k = 0; k < 6; k++) begin
      selector = 16'(k * 4099);
      descType = 2'(k);
      curPriv  = 2'(k);
      @(negedge clk);
      check("R9 idle no response", {61'd0, respValid, grant, fault}, 64'd0);
    end

    // full sweep
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        for (int d = 0; d < 4; d++)
          for (int t = 0; t < 4; t++)
            for (int tb = 0; tb < 2; tb++)
              for (int g = 0; g < 4; g++) begin
                int n;
                int eff;
                bit ok;
                logic [12:0] idx;
                logic [31:0] expOff;
                logic [1:0]  expPriv;
                n   = ((((c*4 + r)*4 + d)*4 + t)*2 + tb)*4 + g;
                idx = 13'((n * 37 + 5) % 8192);
                eff = (c > r) ? c : r;
                case (t)
                  0, 1: ok = (d >= eff);
                  2:    ok = (d >= eff) && (g <= c);
                  default: ok = (d >= eff) && (tb == 0);
                endcase
                expOff  = (ok && t == 2) ? (32'hA000_0000 + 32'(n)) : (32'h0000_5000 + 32'(n));
                expPriv = (ok && t == 2) ? 2'(g) : 2'(c);

                reqValid       = 1'b1;
                selector       = {idx, tb[0], 2'(r)};
                curPriv        = 2'(c);
                descPriv       = 2'(d);
                descType       = 2'(t);
                gateTargetPriv = 2'(g);
                callerOffset   = 32'h0000_5000 + 32'(n);
                gateOffset     = 32'hA000_0000 + 32'(n);
                @(negedge clk);
                reqValid = 1'b0;
                // R2 R5 R6 R7: decision one cycle after acceptance
                check(t == 2 ? "R5 gate decision" : (t == 3 ? "R6 system decision" : "R2 direct decision"),
                      {61'd0, respValid, grant, fault}, {61'd0, 1'b1, ok, !ok});
                // R4
                check("R4 vector", {56'd0, faultVector}, ok ? 64'd0 : 64'h0D);
                // R1
                check("R1 index/table", {50'd0, descIndex, tableSel}, {50'd0, idx, tb[0]});
                // R3 R5
                check(t == 2 ? "R5 gate offset/priv" : "R3 offset/priv",
                      {30'd0, targetOffset, newPriv}, {30'd0, expOff, expPriv});
                @(negedge clk);
                // R4 R7: pulse lasts one cycle
                check("R4 single pulse", {61'd0, respValid, grant, fault}, 64'd0);
              end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule